// File: doc/BRIEF.md
# PC-Relative Token Jump Resolver

The resolver turns a compact 8-bit jump or call token into a full 32-bit target address. Target pointers are kept in a dedicated read-only pointer memory. Code and data live in other memories. Each lookup sees a 256-entry window of that memory. The window's base is computed directly from the current program counter, so it is placed at once for every request and never walks over time.

On a request the block shifts the PC right by `SHIFT` bits to form the window base, then adds the token to get a table index. It reads the pointer and returns it one clock later with a valid strobe. Routines that sit close together in code get windows that overlap, so one pointer entry can serve call sites in several routines. An index that falls past the end of the table raises an error strobe instead of a target.

The table is loaded through a simple write port before execution starts and is static afterwards.

Top module: `token_jump_resolver`

## Requirements
- R1: While reset is held and in the first cycle after it, `target` is 0 and both `target_valid` and `range_err` are 0.
- R2: For a request with program counter P and token T, the index is (P >> SHIFT) + T, with SHIFT=6 by default. If the index is below DEPTH (512 by default), `target` equals the table word at that index in the cycle after the request, and `target_valid` is 1.
- R3: `target_valid` and `range_err` are high only in the cycle after a clock edge at which `req` was high. Without a request both are 0.
- R4: If the index is DEPTH or more, `range_err` is 1 in the next cycle, `target_valid` is 0, and `target` keeps its previous value.
- R5: Two different program counters whose windows overlap can reach the same table entry and return the same target.
- R6: A write (`wr_en` high) stores `wr_data` at `wr_addr` when `req` is low in that cycle. A write in a cycle where `req` is high is ignored, and the entry keeps its old content.
- R7: Token values 0 and 255 both resolve, and the last table index DEPTH-1 is reachable without error.
- R8: Requests on consecutive cycles are each answered in order, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Lookup request |
| pc | input | 32 | Program counter at the jump |
| token | input | 8 | Jump/call token |
| target | output | 32 | Resolved target address |
| target_valid | output | 1 | Target is valid this cycle |
| range_err | output | 1 | Computed index was outside the table |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 9 | Table write index |
| wr_data | input | 32 | Table write data |

## Verification
The hardest case to reach from the ports is a write that coincides with a request. It can only be seen later, through a lookup of the same entry. The bench drives a write and a request in the same cycle, then issues a second lookup that lands on that entry and expects the old pointer back. Out-of-range indices are reached by choosing program counters whose window base sits near the table end, and by one near the top of the address space. After each such case a lookup shows that `target` did not change.

// File: rtl/token_jump_resolver.sv
module token_jump_resolver #(
  parameter int ADDR_W = 32,
  parameter int TOK_W  = 8,
  parameter int SHIFT  = 6,
  parameter int DEPTH  = 512,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SUM_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] pc,
  input  logic [TOK_W-1:0]  token,
  output logic [ADDR_W-1:0] target,
  output logic              target_valid,
  output logic              range_err,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [ADDR_W-1:0] wr_data
);

  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DEPTH);
  localparam logic [IDX_W:0]   WLIMIT = (IDX_W+1)'(DEPTH);

  logic [ADDR_W-1:0] table_mem [DEPTH];
  logic [SUM_W-1:0]  idx_full;
  logic              in_range;

  assign idx_full = SUM_W'(pc >> SHIFT) + SUM_W'(token);
  assign in_range = idx_full < LIMIT;

  always_ff @(posedge clk)
    if (wr_en && !req && ({1'b0, wr_addr} < WLIMIT))
      table_mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target       <= '0;
      target_valid <= 1'b0;
      range_err    <= 1'b0;
    end else begin
      target_valid <= req && in_range;
      range_err    <= req && !in_range;
      if (req && in_range)
        target <= table_mem[idx_full[IDX_W-1:0]];
    end
  end

  // R3
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(target_valid && range_err));

  // R3
  quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!target_valid && !range_err));

  // R8
  answer_every_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (target_valid || range_err));

  // R4
  err_holds_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> $stable(target));

  // R4
  idle_holds_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(target));

endmodule

// File: tb/token_jump_resolver_test.sv
module token_jump_resolver_test;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] pc = '0;
  logic [7:0]  token = '0;
  logic [31:0] target;
  logic        target_valid, range_err;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] last_tgt = '0;
  logic        started = 1'b0;

  typedef struct {
    logic        vld;
    logic        err;
    logic [31:0] tgt;
    string       rq;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  token_jump_resolver uut (
    .clk(clk), .rst_n(rst_n), .req(req), .pc(pc), .token(token),
    .target(target), .target_valid(target_valid), .range_err(range_err),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string rq, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic write_entry(input int a, input logic [31:0] d, input logic with_req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'(a); wr_data = d;
    if (!with_req) model[a] = d;
  endtask

  task automatic issue(input logic [31:0] p, input int t, input string rq);
    int idx;
    exp_t e;
    @(negedge clk);
    req = 1'b1; pc = p; token = 8'(t);
    idx = int'(p / 64) + t;
    e.rq = rq;
    if (p / 64 + 32'(t) < 32'(DEPTH)) begin
      e.vld = 1'b1; e.err = 1'b0; e.tgt = model[idx]; last_tgt = model[idx];
    end else begin
      e.vld = 1'b0; e.err = 1'b1; e.tgt = last_tgt;
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req = 1'b0; wr_en = 1'b0;
    end
  endtask

  initial begin : monitor
    logic r;
    exp_t e;
    wait (started);
    forever begin
      @(posedge clk);
      r = req;
      @(negedge clk);
      if (r) begin
        e = sb.pop_front();
        check({e.rq, " valid/err"}, {32'd0, target_valid, range_err}, {32'd0, e.vld, e.err});
        check({e.rq, " target"}, {2'b0, target}, {2'b0, e.tgt});
      end else begin
        check("R3 idle strobes", {32'd0, target_valid, range_err}, 34'd0);
      end
    end
  end

  initial begin : watchdog
    #1600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {target, target_valid, range_err}, 34'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {target, target_valid, range_err}, 34'd0);
    for (int i = 0; i < DEPTH; i++)
      write_entry(i, 32'h8000_0000 ^ (32'(i) * 32'h0001_0103), 1'b0);
    idle(1);
    started = 1'b1;
    idle(2);
    issue(32'h0000_0000, 0,   "R7 token 0");    idle(1);
    issue(32'h0000_0000, 255, "R7 token 255");  idle(1);
    issue(32'h0000_0A3C, 17,  "R2 basic");      idle(1);
    issue(32'h0000_4000, 255, "R7 last index"); idle(1);
    issue(32'h0000_4040, 255, "R4 one past end"); idle(1);
    issue(32'hFFFF_FFC0, 3,   "R4 high pc");    idle(1);
    issue(32'h0000_1900, 50,  "R5 window A");   idle(1);
    issue(32'h0000_2300, 10,  "R5 window B");   idle(1);
    write_entry(77, 32'h1234_5678, 1'b0);
    idle(1);
    issue(32'h0000_0040, 76,  "R6 write stored"); idle(1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'd77; wr_data = 32'hDEAD_BEEF;
    req = 1'b1; pc = 32'h0; token = 8'd3;
    begin
      exp_t e;
      e.vld = 1'b1; e.err = 1'b0; e.tgt = model[3]; e.rq = "R6 req during write";
      last_tgt = model[3];
      sb.push_back(e);
    end
    idle(1);
    issue(32'h0000_0000, 77, "R6 write ignored"); idle(1);
    issue(32'h0000_0100, 1,  "R8 b2b 1");
    issue(32'h0000_0200, 2,  "R8 b2b 2");
    issue(32'h0000_8000, 0,  "R8 b2b err");
    issue(32'h0000_0300, 3,  "R8 b2b 3");
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule